// File: doc/BRIEF.md
# Shared-Memory Bus Lock with Atomic Test-and-Set

This block places several processor ports in front of one small shared byte memory. A processor asks for the memory by driving its address strobe low. A round-robin arbiter picks one requester, and that port keeps the memory for as long as its strobe stays low. The grant is not released when a single access finishes. Because of this, a read followed by a write under one strobe cannot be interleaved with another processor's traffic.

A port can flag its access as a test-and-set. The block then reads the addressed byte and returns it, together with its top bit as a busy flag. It then writes the same byte back with the top bit forced to one, and only after that gives the acknowledge. When two processors race for a free semaphore byte, exactly one of them sees it free. Ports without a grant get no acknowledge and wait with their requests held, for as long as they keep their strobes low.

Top module: `shmem_tas_lock`

## Requirements
- R1: After reset, every grant and acknowledge is 0, the shared read data is 0x00 and the busy flag is 0.
- R2: At most one port holds a grant in any cycle.
- R3: A granted port keeps its grant for every cycle in which its strobe stays low. The grant is removed at the first clock edge that samples the strobe high.
- R4: When the memory is free, the grant goes to the first requesting port after the previous owner, in ascending index order with wrap-around. Port 0 is first after reset.
- R5: A port without a grant never sees an acknowledge. Its request stays pending while its strobe stays low, and it is served once it wins.
- R6: A write access (write-enable 1, lock-type 0) stores the port's 8-bit data at the port's address.
- R7: A read access (write-enable 0, lock-type 0) drives the stored byte on the shared read data while the acknowledge is high.
- R8: A test-and-set access (lock-type 1, write-enable ignored) returns the byte as it was before the access on the read data. Bit 7 of that byte is returned as the busy flag: 0 means free, 1 means taken.
- R9: A test-and-set leaves the byte with bit 7 set and bits 6..0 unchanged.
- R10: When two ports both test-and-set the same free byte, exactly one of them sees the busy flag as 0.
- R11: With no other owner present, the acknowledge is first seen 2 clock edges after the strobe is sampled low for a read or write, and 3 edges after for a test-and-set. It stays high until the strobe is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_as_n | input | NP | Address strobe per port, active low |
| port_we | input | NP | Per port: 1 means write, 0 means read |
| port_tas | input | NP | Per port lock-type: 1 requests a test-and-set |
| port_addr | input | NP*AW | Byte address per port, packed with port 0 in the low bits |
| port_wdata | input | NP*8 | Write data per port, packed with port 0 in the low bits |
| port_grant | output | NP | One-hot grant of the shared memory |
| port_ack | output | NP | Access done for the granted port |
| bus_rdata | output | 8 | Byte returned by the last read or test-and-set |
| bus_busy | output | 1 | Tested bit of the last test-and-set |

## Verification
The assertions assume that a port keeps its address, data, write-enable and lock-type steady while its strobe is low. They also assume that a port holds its strobe low until it has seen the acknowledge. Under those assumptions, the grant-holding and test-and-set ordering checks describe one complete access per strobe. The stimulus changes port fields only while that port's strobe is high. It releases a strobe only at a falling clock edge after the acknowledge has been observed. It writes every address before it reads that address.

// File: rtl/shmem_tas_pkg.sv
package shmem_tas_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_SETB = 2'd2,
    ST_HOLD = 2'd3
  } lock_st_e;

  localparam int BYTE_W = 8;
  localparam int MARK_BIT = BYTE_W - 1;

  // byte written back by a test-and-set
  function automatic logic [BYTE_W-1:0] mark_taken(input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] r;
    r = b;
    r[MARK_BIT] = 1'b1;
    return r;
  endfunction

  // busy flag reported for a tested byte
  function automatic logic is_taken(input logic [BYTE_W-1:0] b);
    return b[MARK_BIT];
  endfunction

endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int NP = 3,
  localparam int IW = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NP-1:0] req,
  input  logic [IW-1:0] last_idx,
  output logic          any,
  output logic [IW-1:0] win_idx,
  output logic [NP-1:0] win_oh
);

  always_comb begin
    any     = 1'b0;
    win_idx = '0;
    for (int k = 1; k <= NP; k++) begin
      int c;
      c = (int'(last_idx) + k) % NP;
      if (!any && req[c]) begin
        any     = 1'b1;
        win_idx = IW'(c);
      end
    end
  end

  assign win_oh = any ? (NP'(1) << win_idx) : '0;

  // R4: the chosen port is always one that is requesting
  p_pick_is_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_oh & ~req) == '0);

  // R4: some request is always answered with a pick
  p_pick_when_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> any);

endmodule

// File: rtl/lock_byte_ram.sv
module lock_byte_ram
  import shmem_tas_pkg::*;
#(
  parameter int AW = 4,
  localparam int DEPTH = 1 << AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              re,
  input  logic [AW-1:0]     addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata
);

  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem[addr];
  end

  // R9: the read and write halves of an access never share a cycle
  p_no_rw_clash_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && re));

endmodule

// File: rtl/shmem_tas_lock.sv
module shmem_tas_lock
  import shmem_tas_pkg::*;
#(
  parameter int NP = 3,
  parameter int AW = 4,
  localparam int IW = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NP-1:0]      port_as_n,
  input  logic [NP-1:0]      port_we,
  input  logic [NP-1:0]      port_tas,
  input  logic [NP*AW-1:0]   port_addr,
  input  logic [NP*8-1:0]    port_wdata,
  output logic [NP-1:0]      port_grant,
  output logic [NP-1:0]      port_ack,
  output logic [7:0]         bus_rdata,
  output logic               bus_busy
);

  lock_st_e          st_q;
  logic [NP-1:0]     grant_q;
  logic [IW-1:0]     owner_q;
  logic              busy_q;

  // owner's view, brought out as named wires
  logic              owner_live;
  logic              cur_we;
  logic              cur_tas;
  logic [AW-1:0]     cur_addr;
  logic [7:0]        cur_wd;

  logic              pick_any;
  logic [IW-1:0]     pick_idx;
  logic [NP-1:0]     pick_oh;

  logic              ram_we;
  logic              ram_re;
  logic [7:0]        ram_wd;
  logic [7:0]        ram_rd;

  assign owner_live = (|grant_q) && !port_as_n[owner_q];
  assign cur_we     = port_we[owner_q];
  assign cur_tas    = port_tas[owner_q];
  assign cur_addr   = port_addr[int'(owner_q)*AW +: AW];
  assign cur_wd     = port_wdata[int'(owner_q)*8 +: 8];

  rr_pick #(.NP(NP)) u_pick (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (~port_as_n),
    .last_idx (owner_q),
    .any      (pick_any),
    .win_idx  (pick_idx),
    .win_oh   (pick_oh)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      grant_q <= '0;
      owner_q <= IW'(NP - 1);
    end else if (st_q == ST_IDLE) begin
      if (pick_any) begin
        grant_q <= pick_oh;
        owner_q <= pick_idx;
        st_q    <= ST_XFER;
      end
    end else if (!owner_live) begin
      grant_q <= '0;
      st_q    <= ST_IDLE;
    end else begin
      unique case (st_q)
        ST_XFER: st_q <= cur_tas ? ST_SETB : ST_HOLD;
        ST_SETB: st_q <= ST_HOLD;
        default: st_q <= ST_HOLD;
      endcase
    end
  end

  // memory control: read half in XFER, write-back half in SETB
  assign ram_re = owner_live && (st_q == ST_XFER) && (cur_tas || !cur_we);
  assign ram_we = owner_live && (((st_q == ST_XFER) && !cur_tas && cur_we) ||
                                 (st_q == ST_SETB));
  assign ram_wd = (st_q == ST_SETB) ? mark_taken(ram_rd) : cur_wd;

  lock_byte_ram #(.AW(AW)) u_ram (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ram_we),
    .re    (ram_re),
    .addr  (cur_addr),
    .wdata (ram_wd),
    .rdata (ram_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              busy_q <= 1'b0;
    else if (owner_live && st_q == ST_SETB)  busy_q <= is_taken(ram_rd);
  end

  assign port_grant = grant_q;
  assign port_ack   = grant_q & {NP{st_q == ST_HOLD}};
  assign bus_rdata  = ram_rd;
  assign bus_busy   = busy_q;

  // R2: never two owners
  p_one_owner_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(port_grant));

  // R3: a live owner keeps the bus
  p_keep_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    owner_live |=> (port_grant == $past(port_grant)));

  // R3: a released strobe frees the bus at once
  p_drop_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((|grant_q) && !owner_live) |=> (port_grant == '0));

  // R5: an acknowledge only follows a grant held the cycle before
  p_ack_after_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|port_ack) |-> ($past(port_grant) == port_grant));

  // R9: the write-back half always carries the taken mark
  p_mark_on_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && st_q == ST_SETB) |-> ram_wd[7]);

  // R11: the write-back half directly follows a test-and-set read half
  p_tas_order_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SETB) |-> ($past(st_q) == ST_XFER && $past(ram_re)));

endmodule

// File: tb/shmem_tas_lock_tb_top.sv
module shmem_tas_lock_tb_top;

  localparam int NP = 3;
  localparam int AW = 4;
  localparam int NROW = 11;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NP-1:0]     as_n = '1;
  logic [NP-1:0]     we = '0;
  logic [NP-1:0]     tas = '0;
  logic [NP*AW-1:0]  addr = '0;
  logic [NP*8-1:0]   wd = '0;
  logic [NP-1:0]     grant;
  logic [NP-1:0]     ack;
  logic [7:0]        rdata;
  logic              busy;

  int n_cmp = 0;
  int n_bad = 0;
  int last_owner = NP - 1;
  int wd_cnt = 0;
  logic [7:0] res_rd [NP];
  logic       res_busy [NP];

  always #5 clk = ~clk;

  shmem_tas_lock #(.NP(NP), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .port_as_n(as_n), .port_we(we), .port_tas(tas),
    .port_addr(addr), .port_wdata(wd), .port_grant(grant), .port_ack(ack),
    .bus_rdata(rdata), .bus_busy(busy)
  );

  // row: port(2) kind(2: 0 rd, 1 wr, 2 tas) addr(4) wdata(8) exp_rdata(8) exp_busy(1)
  localparam logic [24:0] ROWS [NROW] = '{
    {2'd0, 2'd1, 4'd3, 8'h15, 8'h00, 1'b0},
    {2'd1, 2'd0, 4'd3, 8'h00, 8'h15, 1'b0},
    {2'd2, 2'd2, 4'd3, 8'h00, 8'h15, 1'b0},
    {2'd0, 2'd0, 4'd3, 8'h00, 8'h95, 1'b0},
    {2'd1, 2'd2, 4'd3, 8'h00, 8'h95, 1'b1},
    {2'd2, 2'd1, 4'd5, 8'h80, 8'h00, 1'b0},
    {2'd0, 2'd2, 4'd5, 8'h00, 8'h80, 1'b1},
    {2'd1, 2'd0, 4'd5, 8'h00, 8'h80, 1'b0},
    {2'd1, 2'd1, 4'd0, 8'h7F, 8'h00, 1'b0},
    {2'd2, 2'd2, 4'd0, 8'h00, 8'h7F, 1'b0},
    {2'd0, 2'd0, 4'd0, 8'h00, 8'hFF, 1'b0}
  };

  task automatic check(input int act, input int exp, input string req, input string what);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic set_port(input int p, input bit w, input bit t, input int a, input logic [7:0] d);
    we[p] = w;
    tas[p] = t;
    addr[p*AW +: AW] = AW'(a);
    wd[p*8 +: 8] = d;
  endtask

  function automatic int rr_next(input int last, input logic [NP-1:0] m);
    for (int k = 1; k <= NP; k++) begin
      if (m[(last + k) % NP]) return (last + k) % NP;
    end
    return -1;
  endfunction

  // assert strobes of mask, serve them one by one in arbitration order
  task automatic serve(input logic [NP-1:0] mask, input int exp_lat);
    logic [NP-1:0] rem;
    int lat;
    rem = mask;
    @(negedge clk);
    as_n = as_n & ~mask;
    lat = 0;
    while (rem != '0) begin
      int i;
      int guard;
      int e;
      i = -1;
      guard = 0;
      while (i < 0 && guard < 30) begin
        @(negedge clk);
        lat++;
        guard++;
        for (int k = 0; k < NP; k++) if (ack[k]) i = k;
      end
      if (i < 0) begin
        check(0, 1, "R11", "no acknowledge");
        as_n = '1;
        return;
      end
      e = rr_next(last_owner, rem);
      check(i, e, "R4", "served port");
      if (exp_lat > 0) check(lat, exp_lat, "R11", "ack latency");
      check(int'(grant[i]), 1, "R3", "grant with ack");
      check($countones(grant), 1, "R2", "owner count");
      check(int'(ack & ~(NP'(1) << i)), 0, "R5", "ack to non-owner");
      res_rd[i] = rdata;
      res_busy[i] = busy;
      if ((rem & ~(NP'(1) << i)) != '0) begin
        for (int h = 0; h < 2; h++) begin
          @(negedge clk);
          check(int'(grant), int'(NP'(1) << i), "R3", "grant held");
          check(int'(ack), int'(NP'(1) << i), "R5", "waiter not acked");
        end
      end
      as_n[i] = 1'b1;
      last_owner = i;
      rem[i] = 1'b0;
      @(negedge clk);
      lat = 0;
      check(int'(grant[i]), 0, "R3", "grant released");
    end
  endtask

  always @(posedge clk) begin
    wd_cnt++;
    if (wd_cnt > 100000) begin
      n_bad++;
      $display("FAIL watchdog expired: actual %0d expected below %0d", wd_cnt, 100000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(int'(grant), 0, "R1", "grant");
    check(int'(ack), 0, "R1", "ack");
    check(int'(rdata), 0, "R1", "rdata");
    check(int'(busy), 0, "R1", "busy");
    rst_n = 1'b1;
    @(negedge clk);

    // vector table, one port at a time
    for (int r = 0; r < NROW; r++) begin
      int p;
      int kind;
      p = int'(ROWS[r][24:23]);
      kind = int'(ROWS[r][22:21]);
      set_port(p, kind == 1, kind == 2, int'(ROWS[r][20:17]), ROWS[r][16:9]);
      serve(NP'(1) << p, (kind == 2) ? 3 : 2);
      if (kind == 0) check(int'(res_rd[p]), int'(ROWS[r][8:1]), "R6 R7 R9", "read byte");
      if (kind == 2) begin
        check(int'(res_rd[p]), int'(ROWS[r][8:1]), "R8", "tested byte");
        check(int'(res_busy[p]), int'(ROWS[r][0]), "R8", "busy flag");
      end
    end

    // two test-and-sets race for one free byte
    set_port(2, 1'b1, 1'b0, 9, 8'h21);
    serve(3'b100, 2);
    set_port(0, 1'b0, 1'b1, 9, 8'h00);
    set_port(1, 1'b1, 1'b1, 9, 8'h00);
    serve(3'b011, 0);
    check(int'(res_busy[0]) + int'(res_busy[1]), 1, "R10", "free winners");
    check(int'(res_busy[rr_next(2, 3'b011)]), 0, "R10", "first owner sees free");
    set_port(2, 1'b0, 1'b0, 9, 8'h00);
    serve(3'b100, 2);
    check(int'(res_rd[2]), 8'hA1, "R9", "byte after race");

    // all three ports read at once: order follows round robin
    set_port(1, 1'b1, 1'b0, 1, 8'h5A);
    serve(3'b010, 2);
    for (int p = 0; p < NP; p++) set_port(p, 1'b0, 1'b0, 1, 8'h00);
    serve(3'b111, 0);
    for (int p = 0; p < NP; p++) check(int'(res_rd[p]), 8'h5A, "R5", "waiter served");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule